// File: doc/BRIEF.md
# Power Management Event Register Block

This block holds the fixed power-management event state of a chip: a 16-bit status register of sticky event flags and a 16-bit enable register beside it. Both sit on a small 16-bit register bus that accepts byte or word writes. Hardware event inputs set the status flags: bus-master activity, a firmware attention request, the power button, the sleep button, an RTC alarm, PCI Express wake sources and a wake signal. A free-running timer also sets a flag. Software clears a flag by writing 1 to it.

Every status flag is ANDed with its enable bit, and the results are ORed into one level request. A mode bit sends that request to one of two outputs: the system control interrupt in the newer mode, or the legacy management interrupt in the legacy mode. A build parameter can remove the legacy mode. In that build the mode bit always reads 1.

The free-running counter width is a parameter, normally 24 or 32 bits. Each change of the counter's top bit raises the timer flag. Software can read the counter through two bus words.

Top module: `pmev_regs`

## Requirements
- R1: While reset is held, and just after it, the status, enable, mode and counter all read 0, and both interrupt outputs are low.
- R2: Register map (16-bit words, byte address `bus_addr`, bit 0 must be 0): status at 0, enable at 2, mode at 4 (bit 0), counter bits 15:0 at 8, and the upper counter bits zero-extended at 10. In status and enable, only bits 0, 4, 5, 8, 9, 10, 14 and 15 exist (implemented mask 0xC731). All other bits read 0, and writes to them have no effect.
- R3: A write changes bits 7:0 only when `bus_be[0]` is set, and bits 15:8 only when `bus_be[1]` is set.
- R4: When an event input is high at a clock edge, its status bit reads 1 after that edge: bus master to bit 4, firmware request to bit 5, power button to bit 8, sleep button to bit 9, RTC alarm to bit 10, wake to bit 15. Software writes never set a status bit.
- R5: Writing 1 to a status bit clears it, and writing 0 leaves it alone. If hardware sets a bit in the same cycle that software clears it, the bit stays 1.
- R6: Status bit 14 is set while `pcie_wake_i` is high. A write of 1 does not clear it while the input stays high. After the input drops, the bit stays set until it is written with 1.
- R7: The counter increments by one every clock after reset. Status bit 0 is set each time the counter's top bit changes, whether it goes 0 to 1 or 1 to 0.
- R8: When any status bit and its enable bit are both 1, the request is active. With mode 0 the request drives `smi_o` and `sci_o` stays low. With mode 1 it drives `sci_o` and `smi_o` stays low.
- R9: When `NEW_MODE_ONLY` is 1, the mode bit reads 1 and writes to it are ignored, so requests always go to `sci_o`.
- R10: Two successive counter reads one clock apart differ by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 4 | Byte address of the register word |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 2 | Byte lane enables for the write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| bm_req_i | input | 1 | Bus-master request event |
| gbl_req_i | input | 1 | Firmware attention event |
| pwrbtn_i | input | 1 | Power button press event |
| slpbtn_i | input | 1 | Sleep button press event |
| rtc_alarm_i | input | 1 | RTC alarm event |
| pcie_wake_i | input | 1 | Level-sensitive PCI Express wake indication |
| wake_evt_i | input | 1 | Enabled wake event |
| sci_o | output | 1 | System control interrupt request (level) |
| smi_o | output | 1 | Legacy management interrupt request (level) |

## Verification
A table of word and single-lane writes, each followed by a read-back, separates the implemented mask from the reserved bits and separates the two byte lanes. Each pulsed event source is checked in turn, with a clear between them, so a wrong bit position shows up. A same-cycle set and clear shows which of the two wins. Holding the PCI Express level through a clear separates level behaviour from sticky behaviour. The timer is watched across both top-bit transitions, and the interrupt outputs are compared between the two mode settings and a build with the legacy mode removed.

// File: rtl/pmev_pkg.sv
package pmev_pkg;
  localparam int REG_W = 16;
  // status / enable bit positions (software decodes these)
  localparam int B_TMR  = 0;
  localparam int B_BM   = 4;
  localparam int B_GBL  = 5;
  localparam int B_PWR  = 8;
  localparam int B_SLP  = 9;
  localparam int B_RTC  = 10;
  localparam int B_PCIE = 14;
  localparam int B_WAK  = 15;
  localparam logic [REG_W-1:0] IMPL_MASK =
    (16'h1 << B_TMR) | (16'h1 << B_BM)  | (16'h1 << B_GBL)  | (16'h1 << B_PWR) |
    (16'h1 << B_SLP) | (16'h1 << B_RTC) | (16'h1 << B_PCIE) | (16'h1 << B_WAK);
  // word selects (bus_addr[3:1])
  typedef enum logic [2:0] {
    SEL_STS = 3'd0, SEL_EN = 3'd1, SEL_MODE = 3'd2, SEL_CLO = 3'd4, SEL_CHI = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/pmev_rst_sync.sv
module pmev_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/pmev_timer.sv
module pmev_timer #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_o,
  output logic             toggle_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             msb_q;

  always_comb cnt_d = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      msb_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      msb_q <= cnt_q[CNT_W-1];
    end
  end

  assign cnt_o    = cnt_q;
  assign toggle_o = cnt_q[CNT_W-1] ^ msb_q;

  AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q - $past(cnt_q)) == CNT_W'(1)); // R7
endmodule

// File: rtl/pmev_status.sv
module pmev_status
  import pmev_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_i,
  input  logic [REG_W-1:0] lvl_i,
  input  logic [REG_W-1:0] clr_i,
  output logic [REG_W-1:0] sts_o
);
  logic [REG_W-1:0] sts_q, sts_d, eff_clr;

  always_comb begin
    eff_clr = clr_i & ~lvl_i;
    sts_d   = ((sts_q & ~eff_clr) | set_i | lvl_i) & IMPL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_d;
  end

  assign sts_o = sts_q;

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i & IMPL_MASK) != '0 |=> (sts_o & $past(set_i & IMPL_MASK)) == $past(set_i & IMPL_MASK)); // R4
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i & ~set_i & ~lvl_i) != '0 |=> (sts_o & $past(clr_i & ~set_i & ~lvl_i)) == '0); // R5
  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_i[B_PCIE] |=> sts_o[B_PCIE]); // R6
endmodule

// File: rtl/pmev_route.sv
module pmev_route
  import pmev_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] sts_i,
  input  logic [REG_W-1:0] en_i,
  input  logic             mode_i,
  output logic             sci_o,
  output logic             smi_o
);
  logic req;
  always_comb begin
    req   = |(sts_i & en_i);
    sci_o = req & mode_i;
    smi_o = req & ~mode_i;
  end

  AST_ROUTE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sci_o && smi_o)); // R8
endmodule

// File: rtl/pmev_regs.sv
module pmev_regs
  import pmev_pkg::*;
#(
  parameter int CNT_W         = 24,
  parameter bit NEW_MODE_ONLY = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [1:0]  bus_be,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        bm_req_i,
  input  logic        gbl_req_i,
  input  logic        pwrbtn_i,
  input  logic        slpbtn_i,
  input  logic        rtc_alarm_i,
  input  logic        pcie_wake_i,
  input  logic        wake_evt_i,
  output logic        sci_o,
  output logic        smi_o
);
  localparam int EXT_W = 32;

  logic             rst_n_s;
  logic [CNT_W-1:0] cnt;
  logic             tmr_tgl;
  logic [REG_W-1:0] lane_mask, set_vec, lvl_vec, clr_vec, sts;
  logic [REG_W-1:0] en_q, en_d;
  logic             mode, hit_sts, hit_en, hit_mode;
  logic [EXT_W-1:0] cnt_ext;
  reg_sel_e         sel;

  pmev_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  pmev_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n_s), .cnt_o(cnt), .toggle_o(tmr_tgl));

  // bus decode
  always_comb begin
    sel       = reg_sel_e'(bus_addr[3:1]);
    lane_mask = {{8{bus_be[1]}}, {8{bus_be[0]}}};
    hit_sts   = bus_wr && !bus_addr[0] && sel == SEL_STS;
    hit_en    = bus_wr && !bus_addr[0] && sel == SEL_EN;
    hit_mode  = bus_wr && !bus_addr[0] && sel == SEL_MODE && bus_be[0];
  end

  // event sources into status
  always_comb begin
    set_vec         = '0;
    set_vec[B_TMR]  = tmr_tgl;
    set_vec[B_BM]   = bm_req_i;
    set_vec[B_GBL]  = gbl_req_i;
    set_vec[B_PWR]  = pwrbtn_i;
    set_vec[B_SLP]  = slpbtn_i;
    set_vec[B_RTC]  = rtc_alarm_i;
    set_vec[B_WAK]  = wake_evt_i;
    lvl_vec         = '0;
    lvl_vec[B_PCIE] = pcie_wake_i;
    clr_vec         = hit_sts ? (bus_wdata & lane_mask) : '0;
  end

  pmev_status u_sts (
    .clk(clk), .rst_n(rst_n_s), .set_i(set_vec), .lvl_i(lvl_vec),
    .clr_i(clr_vec), .sts_o(sts));

  // enable register
  always_comb begin
    en_d = en_q;
    if (hit_en) en_d = ((en_q & ~lane_mask) | (bus_wdata & lane_mask)) & IMPL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) en_q <= '0;
    else          en_q <= en_d;
  end

  // mode bit
  generate
    if (NEW_MODE_ONLY) begin : g_fixed_mode
      assign mode = 1'b1;
    end else begin : g_mode_reg
      logic mode_q, mode_d;
      always_comb mode_d = hit_mode ? bus_wdata[0] : mode_q;
      always_ff @(posedge clk or negedge rst_n_s) begin
        if (!rst_n_s) mode_q <= 1'b0;
        else          mode_q <= mode_d;
      end
      assign mode = mode_q;
      AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n_s)
        hit_mode |=> mode == $past(bus_wdata[0])); // R8
    end
  endgenerate

  pmev_route u_route (
    .clk(clk), .rst_n(rst_n_s), .sts_i(sts), .en_i(en_q), .mode_i(mode),
    .sci_o(sci_o), .smi_o(smi_o));

  // read mux
  always_comb begin
    cnt_ext   = EXT_W'(cnt);
    bus_rdata = '0;
    if (!bus_addr[0]) begin
      case (sel)
        SEL_STS:  bus_rdata = sts;
        SEL_EN:   bus_rdata = en_q;
        SEL_MODE: bus_rdata = {15'd0, mode};
        SEL_CLO:  bus_rdata = cnt_ext[15:0];
        SEL_CHI:  bus_rdata = cnt_ext[31:16];
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: tb/pmev_regs_tb.sv
`timescale 1ns/100ps
module pmev_regs_tb_top;
  localparam int TW = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic        bus_wr;
  logic [1:0]  bus_be;
  logic [15:0] bus_wdata, rdata_a, rdata_b;
  logic [5:0]  ev;        // 0 bm,1 gbl,2 pwr,3 slp,4 rtc,5 wake
  logic        pcie;
  logic        sci_a, smi_a, sci_b, smi_b;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  pmev_regs #(.CNT_W(TW), .NEW_MODE_ONLY(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .bm_req_i(ev[0]), .gbl_req_i(ev[1]),
    .pwrbtn_i(ev[2]), .slpbtn_i(ev[3]), .rtc_alarm_i(ev[4]), .pcie_wake_i(pcie),
    .wake_evt_i(ev[5]), .sci_o(sci_a), .smi_o(smi_a));

  pmev_regs #(.CNT_W(TW), .NEW_MODE_ONLY(1'b1)) dut_b (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .bm_req_i(ev[0]), .gbl_req_i(ev[1]),
    .pwrbtn_i(ev[2]), .slpbtn_i(ev[3]), .rtc_alarm_i(ev[4]), .pcie_wake_i(pcie),
    .wake_evt_i(ev[5]), .sci_o(sci_b), .smi_o(smi_b));

  // {wr, addr[3:0], be[1:0], data[15:0], expect[15:0]}
  localparam int NV = 13;
  localparam logic [38:0] VEC [NV] = '{
    {1'b0, 4'd0, 2'b11, 16'h0000, 16'h0000},  // R1 status zero
    {1'b1, 4'd2, 2'b11, 16'hFFFF, 16'h0000},
    {1'b0, 4'd2, 2'b11, 16'h0000, 16'hC731},  // R2 implemented mask
    {1'b1, 4'd2, 2'b01, 16'h0000, 16'h0000},
    {1'b0, 4'd2, 2'b11, 16'h0000, 16'hC700},  // R3 low lane only
    {1'b1, 4'd2, 2'b10, 16'h0000, 16'h0000},
    {1'b0, 4'd2, 2'b11, 16'h0000, 16'h0000},  // R3 high lane only
    {1'b1, 4'd4, 2'b11, 16'hFFFF, 16'h0000},
    {1'b0, 4'd4, 2'b11, 16'h0000, 16'h0001},  // R2 mode bit 0
    {1'b1, 4'd4, 2'b10, 16'h0000, 16'h0000},
    {1'b0, 4'd4, 2'b11, 16'h0000, 16'h0001},  // R3 high lane leaves mode
    {1'b1, 4'd0, 2'b11, 16'hFFFF, 16'h0000},
    {1'b0, 4'd0, 2'b11, 16'h0000, 16'h0000}   // R4 writes never set
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #0.5 d = rdata_a;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    ev[idx] = 1'b1;
    @(negedge clk);
    ev[idx] = 1'b0;
  endtask

  task automatic wait_cnt(input logic [15:0] v);
    logic [15:0] c;
    c = 16'hFFFF;
    while (c != v) rd(4'd8, c);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  localparam int EVB [6] = '{4, 5, 8, 9, 10, 15};

  initial begin
    logic [15:0] r, r2;
    rst_n = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_be = '0; bus_wdata = '0;
    ev = '0; pcie = 1'b0;
    #3 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    bus_addr = 4'd8; #0.5 check("R1 counter", rdata_a, 16'h0000);
    bus_addr = 4'd0; #0.5 check("R1 status", rdata_a, 16'h0000);
    check("R1 irq", {14'd0, sci_a, smi_a}, 16'h0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // vector table (status reads ignore the timer bit)
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][38]) wr(VEC[i][37:34], VEC[i][33:32], VEC[i][31:16]);
      else begin
        rd(VEC[i][37:34], r);
        if (VEC[i][37:34] == 4'd0) r[0] = 1'b0;
        check($sformatf("R2/R3 vec %0d", i), r, VEC[i][15:0]);
      end
    end
    wr(4'd4, 2'b01, 16'h0000);

    // R4 each event source to its bit
    for (int k = 0; k < 6; k++) begin
      pulse(k);
      rd(4'd0, r); r[0] = 1'b0;
      check("R4 event bit", r, 16'h1 << EVB[k]);
      wr(4'd0, 2'b11, 16'h1 << EVB[k]);
      rd(4'd0, r); r[0] = 1'b0;
      check("R5 w1c", r, 16'h0000);
    end

    // R5 write 0 no effect, set wins over clear
    pulse(4);
    wr(4'd0, 2'b11, 16'h0000);
    rd(4'd0, r); r[0] = 1'b0;
    check("R5 write zero", r, 16'h0400);
    @(negedge clk);
    bus_addr = 4'd0; bus_be = 2'b11; bus_wdata = 16'h0400; bus_wr = 1'b1; ev[4] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; ev[4] = 1'b0;
    rd(4'd0, r); r[0] = 1'b0;
    check("R5 set wins", r, 16'h0400);
    wr(4'd0, 2'b11, 16'h0400);

    // R6 level bit
    @(negedge clk); pcie = 1'b1;
    rd(4'd0, r); r[0] = 1'b0;
    check("R6 level set", r, 16'h4000);
    wr(4'd0, 2'b11, 16'h4000);
    rd(4'd0, r); r[0] = 1'b0;
    check("R6 clear blocked", r, 16'h4000);
    pcie = 1'b0;
    rd(4'd0, r); r[0] = 1'b0;
    check("R6 sticky after drop", r, 16'h4000);
    wr(4'd0, 2'b11, 16'h4000);
    rd(4'd0, r); r[0] = 1'b0;
    check("R6 clear after drop", r, 16'h0000);

    // R8 / R9 routing
    pulse(2);
    wr(4'd2, 2'b11, 16'h0100);
    @(negedge clk);
    check("R8 mode0 smi", {14'd0, sci_a, smi_a}, 16'h0001);
    check("R9 fixed mode sci", {14'd0, sci_b, smi_b}, 16'h0002);
    wr(4'd4, 2'b01, 16'h0001);
    @(negedge clk);
    check("R8 mode1 sci", {14'd0, sci_a, smi_a}, 16'h0002);
    wr(4'd4, 2'b01, 16'h0000);
    @(negedge clk); bus_addr = 4'd4; #0.5
    check("R9 mode reads one", rdata_b, 16'h0001);
    wr(4'd0, 2'b11, 16'h0100);
    @(negedge clk);
    check("R8 cleared", {14'd0, sci_a, smi_a}, 16'h0000);
    wr(4'd2, 2'b11, 16'h0000);

    // R10 counter reads
    rd(4'd8, r); rd(4'd8, r2);
    check("R10 step", r2 - r, 16'h0001);
    rd(4'd10, r);
    check("R10 high zero", r, 16'h0000);

    // R7 timer flag on both edges of the top bit
    wait_cnt(16'd1000);
    wr(4'd0, 2'b01, 16'h0001);
    rd(4'd0, r);
    check("R7 cleared", r & 16'h0001, 16'h0000);
    wait_cnt(16'd3);
    rd(4'd0, r);
    check("R7 falling top bit", r & 16'h0001, 16'h0001);
    wr(4'd0, 2'b01, 16'h0001);
    wait_cnt(16'd500);
    rd(4'd0, r);
    check("R7 quiet mid", r & 16'h0001, 16'h0000);
    wait_cnt(16'd520);
    rd(4'd0, r);
    check("R7 rising top bit", r & 16'h0001, 16'h0001);

    finish_run();
  end
endmodule